// File: doc/BRIEF.md
# Vector Shift-Right-and-Insert Unit

This block is a registered, lane-parallel datapath for one vector operation. It decodes a 32-bit instruction word and splits the vector into elements of 8, 16, 32 or 64 bits. Each source element is shifted right logically by an immediate amount. The shifted value is then merged into the matching destination element. The destination bits above the shifted value are kept. The bits the shift fills are replaced. No predicate is applied.

A single immediate field selects both the element size and the shift amount. The upstream pipeline supplies the current source and destination vector values together with the instruction word. One cycle later it receives the merged vector, the two register indices taken from the word, and a flag that marks an encoding this unit must not execute. When that flag is set, the destination value comes back unchanged. The vector length is a parameter that must be a multiple of 64 bits.

Top module: `vsri_unit`

## Requirements
- R1: While reset is asserted, out_valid, out_undef, out_rd, out_rn and out_result are all zero.
- R2: out_valid is high in the cycle after a cycle in which in_valid was high, and low otherwise. The result, indices and flag shown with it belong to that accepted input.
- R3: The word is recognized only when bits 31:24 equal 8'h45, bit 21 is 0 and bits 15:10 equal 6'b111100. Any other word sets out_undef and returns in_dst unchanged as out_result.
- R4: The size field is {bits 23:22, bits 20:19}. When it equals 4'b0000, out_undef is set and out_result equals in_dst.
- R5: The element size is 8 shifted left by the index of the highest set bit of the size field: 8 for 0001, 16 for 001x, 32 for 01xx and 64 for 1xxx.
- R6: The shift amount is twice the element size minus the unsigned value of {size field, bits 18:16}. Each element of out_result is (dst AND NOT (all-ones >> shift)) OR (src >> shift), with logical shifts.
- R7: A shift equal to the element size returns the destination element unchanged.
- R8: A shift of 1 keeps only the top bit of each destination element and fills the rest with the source element's upper bits.
- R9: out_rn carries bits 9:5 and out_rd carries bits 4:0 of the accepted word, whether or not it is recognized.
- R10: Every element across the full vector length is processed independently by the same rule.
- R11: In a cycle with no valid input, out_result, out_rd, out_rn and out_undef keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and word are present this cycle |
| in_instr | input | 32 | Instruction word |
| in_src | input | VLEN | Source vector value |
| in_dst | input | VLEN | Current destination vector value |
| out_valid | output | 1 | Result is present this cycle |
| out_result | output | VLEN | Merged destination vector |
| out_rd | output | 5 | Destination register index |
| out_rn | output | 5 | Source register index |
| out_undef | output | 1 | Word not executable; result equals old destination |

## Verification
There is a single register stage, so every wrong internal decision appears at the ports on the cycle after the input. A wrong size decode corrupts the element boundaries across the whole vector. A wrong shift subtraction moves the boundary between the kept and inserted bits in every element. A wrong full-width guard leaks source bits into elements that should pass through. Every size is swept over every legal shift against an element-wise model, so each of these faults shows in the first result that uses the affected case.

// File: rtl/vsri_pkg.sv
package vsri_pkg;

    localparam logic [7:0] OPC_TOP  = 8'h45;
    localparam logic [5:0] OPC_MID  = 6'b111100;
    localparam int         CHUNK_W  = 64;
    localparam int         NSIZES   = 4;

    // size code: 0 -> 8 bit, 1 -> 16, 2 -> 32, 3 -> 64
    typedef logic [1:0] size_code_t;

    typedef struct packed {
        logic       legal;
        size_code_t size;
        logic [6:0] shift;
        logic [4:0] rn;
        logic [4:0] rd;
    } dec_t;

endpackage

// File: rtl/vsri_decode.sv
module vsri_decode
    import vsri_pkg::*;
(
    input  logic [31:0] instr,
    output dec_t        dec
);
    logic [3:0] tsz;
    logic [2:0] imm;
    logic       opc_ok;
    size_code_t code;
    logic [7:0] twice_w;
    logic [7:0] diff;

    always_comb begin
        tsz    = {instr[23:22], instr[20:19]};
        imm    = instr[18:16];
        opc_ok = (instr[31:24] == OPC_TOP) && !instr[21] && (instr[15:10] == OPC_MID);
        casez (tsz)
            4'b1???: code = 2'd3;
            4'b01??: code = 2'd2;
            4'b001?: code = 2'd1;
            default: code = 2'd0;
        endcase
        twice_w = 8'd16 << code;
        diff    = twice_w - {1'b0, tsz, imm};

        dec.legal = opc_ok && (tsz != 4'b0000);
        dec.size  = code;
        dec.shift = diff[6:0];
        dec.rn    = instr[9:5];
        dec.rd    = instr[4:0];
    end
endmodule

// File: rtl/vsri_elem.sv
module vsri_elem #(
    parameter int EW = 8
) (
    input  logic [EW-1:0] src,
    input  logic [EW-1:0] dst,
    input  logic [6:0]    shift,
    output logic [EW-1:0] res
);
    localparam logic [7:0]    EW_W = 8'(EW);
    localparam logic [EW-1:0] ONES = '1;

    logic          full;
    logic [EW-1:0] mask;
    logic [EW-1:0] moved;

    always_comb begin
        full  = ({1'b0, shift} >= EW_W);
        mask  = full ? '0 : (ONES >> shift);
        moved = full ? '0 : (src >> shift);
        res   = (dst & ~mask) | moved;
    end
endmodule

// File: rtl/vsri_chunk.sv
module vsri_chunk
    import vsri_pkg::*;
(
    input  logic [CHUNK_W-1:0] src,
    input  logic [CHUNK_W-1:0] dst,
    input  size_code_t         size,
    input  logic [6:0]         shift,
    output logic [CHUNK_W-1:0] res
);
    logic [CHUNK_W-1:0] per_size [NSIZES];

    for (genvar g = 0; g < NSIZES; g++) begin : g_size
        localparam int EW = 8 << g;
        localparam int NE = CHUNK_W / EW;
        for (genvar e = 0; e < NE; e++) begin : g_elem
            vsri_elem #(.EW(EW)) i_elem (
                .src   (src[e*EW +: EW]),
                .dst   (dst[e*EW +: EW]),
                .shift (shift),
                .res   (per_size[g][e*EW +: EW])
            );
        end
    end

    always_comb begin
        res = per_size[size];
    end
endmodule

// File: rtl/vsri_unit.sv
module vsri_unit
    import vsri_pkg::*;
#(
    parameter int VLEN = 128
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [31:0]     in_instr,
    input  logic [VLEN-1:0] in_src,
    input  logic [VLEN-1:0] in_dst,
    output logic            out_valid,
    output logic [VLEN-1:0] out_result,
    output logic [4:0]      out_rd,
    output logic [4:0]      out_rn,
    output logic            out_undef
);
    localparam int NCHUNK = VLEN / CHUNK_W;

    typedef struct packed {
        logic            valid;
        logic            undef;
        logic [4:0]      rd;
        logic [4:0]      rn;
        logic [VLEN-1:0] result;
    } st_t;

    dec_t            dec;
    logic [VLEN-1:0] merged;
    st_t             st_d, st_q;

    vsri_decode i_decode (
        .instr (in_instr),
        .dec   (dec)
    );

    for (genvar c = 0; c < NCHUNK; c++) begin : g_chunk
        vsri_chunk i_chunk (
            .src   (in_src[c*CHUNK_W +: CHUNK_W]),
            .dst   (in_dst[c*CHUNK_W +: CHUNK_W]),
            .size  (dec.size),
            .shift (dec.shift),
            .res   (merged[c*CHUNK_W +: CHUNK_W])
        );
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.undef  = !dec.legal;
            st_d.rd     = dec.rd;
            st_d.rn     = dec.rn;
            st_d.result = dec.legal ? merged : in_dst;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid  = st_q.valid;
    assign out_undef  = st_q.undef;
    assign out_rd     = st_q.rd;
    assign out_rn     = st_q.rn;
    assign out_result = st_q.result;
endmodule

// File: rtl/vsri_unit_chk.sv
module vsri_unit_chk #(
    parameter int VLEN = 128
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [31:0]     in_instr,
    input logic [VLEN-1:0] in_dst,
    input logic            out_valid,
    input logic [VLEN-1:0] out_result,
    input logic [4:0]      out_rd,
    input logic [4:0]      out_rn,
    input logic            out_undef
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |-> (!out_valid && !out_undef));

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R3
    undef_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_instr[31:24] != 8'h45)) |=> (out_undef && out_result == $past(in_dst)));

    // R4
    zero_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && {in_instr[23:22], in_instr[20:19]} == 4'b0000) |=> (out_undef && out_result == $past(in_dst)));

    // R9
    index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_rd == $past(in_instr[4:0]) && out_rn == $past(in_instr[9:5])));

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !in_valid) |=> ($stable(out_result) && $stable(out_undef) && $stable(out_rd)));
endmodule

bind vsri_unit vsri_unit_chk #(.VLEN(VLEN)) i_vsri_unit_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_instr   (in_instr),
    .in_dst     (in_dst),
    .out_valid  (out_valid),
    .out_result (out_result),
    .out_rd     (out_rd),
    .out_rn     (out_rn),
    .out_undef  (out_undef)
);

// File: tb/test_vsri_unit.sv
module test_vsri_unit;
    localparam int VL     = 128;
    localparam int CLK_NS = 10;

    logic          clk = 0;
    logic          rst_n = 0;
    logic          in_valid = 0;
    logic [31:0]   in_instr = '0;
    logic [VL-1:0] in_src = '0;
    logic [VL-1:0] in_dst = '0;
    logic          out_valid;
    logic [VL-1:0] out_result;
    logic [4:0]    out_rd, out_rn;
    logic          out_undef;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic [VL-1:0] res;
        logic [4:0]    rd;
        logic [4:0]    rn;
        logic          undef;
        string         tag;
    } exp_t;

    exp_t          sb[$];
    logic [VL-1:0] last_res;

    always #(CLK_NS/2) clk = ~clk;

    vsri_unit #(.VLEN(VL)) i_vsri_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
        .in_src(in_src), .in_dst(in_dst), .out_valid(out_valid),
        .out_result(out_result), .out_rd(out_rd), .out_rn(out_rn), .out_undef(out_undef)
    );

    function automatic logic [VL-1:0] model(input logic [31:0] w, input logic [VL-1:0] s, input logic [VL-1:0] d);
        logic [3:0]    ts;
        int            esz, sh, v;
        logic [VL-1:0] r;
        logic [63:0]   em, a, b, mk, o;
        ts = {w[23:22], w[20:19]};
        r  = d;
        if (w[31:24] != 8'h45 || w[21] || w[15:10] != 6'b111100 || ts == 4'd0) return d;
        esz = ts[3] ? 64 : ts[2] ? 32 : ts[1] ? 16 : 8;
        v   = int'({ts, w[18:16]});
        sh  = 2 * esz - v;
        em  = (esz == 64) ? '1 : ((64'd1 << esz) - 64'd1);
        for (int e = 0; e < VL / esz; e++) begin
            a  = 64'(s >> (e * esz)) & em;
            b  = 64'(d >> (e * esz)) & em;
            mk = (sh >= esz) ? 64'd0 : (em >> sh);
            o  = (b & ~mk) | ((a >> sh) & em);
            for (int k = 0; k < esz; k++) r[e * esz + k] = o[k];
        end
        return r;
    endfunction

    function automatic logic [31:0] mk_word(input int esz, input int sh, input logic [4:0] rn, input logic [4:0] rd);
        logic [6:0] v;
        v = 7'(2 * esz - sh);
        return {8'h45, v[6:5], 1'b0, v[4:3], v[2:0], 6'b111100, rn, rd};
    endfunction

    function automatic logic [VL-1:0] rnd_vec();
        logic [VL-1:0] x;
        for (int i = 0; i < VL / 32; i++) x[i*32 +: 32] = $urandom;
        return x;
    endfunction

    task automatic send(input logic [31:0] w, input logic [VL-1:0] s, input logic [VL-1:0] d, input string tag);
        exp_t it;
        @(negedge clk);
        in_valid = 1;
        in_instr = w;
        in_src   = s;
        in_dst   = d;
        it.res   = model(w, s, d);
        it.rd    = w[4:0];
        it.rn    = w[9:5];
        it.undef = (model(w, s, d) === d) && (w[31:24] != 8'h45 || w[21] || w[15:10] != 6'b111100 || {w[23:22], w[20:19]} == 4'd0);
        it.tag   = tag;
        last_res = it.res;
        sb.push_back(it);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 0;
    endtask

    // monitor: compare each result against the queue head
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            exp_t it;
            checks++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL R2 unexpected out_valid: actual 1 expected 0");
            end else begin
                it = sb.pop_front();
                if (out_result !== it.res || out_rd !== it.rd || out_rn !== it.rn || out_undef !== it.undef) begin
                    errors++;
                    $display("FAIL %s: actual res=%h rd=%0d rn=%0d undef=%b expected res=%h rd=%0d rn=%0d undef=%b",
                             it.tag, out_result, out_rd, out_rn, out_undef, it.res, it.rd, it.rn, it.undef);
                end
            end
        end
    end

    task automatic check(input bit ok, input string msg);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s", msg);
        end
    endtask

    initial begin
        logic [VL-1:0] d;
        repeat (3) @(negedge clk);
        // R1
        check(out_valid === 0 && out_result === '0 && out_undef === 0 && out_rd === 0 && out_rn === 0,
              $sformatf("R1 reset: actual valid=%b res=%h expected 0", out_valid, out_result));
        rst_n = 1;
        @(negedge clk);
        // R2: no input yet
        check(out_valid === 0, $sformatf("R2 idle after reset: actual %b expected 0", out_valid));

        // R5 R6 R10: every size, every shift; R7 at sh==esz, R8 at sh==1
        for (int g = 0; g < 4; g++) begin
            for (int sh = 1; sh <= (8 << g); sh++) begin
                string tag;
                tag = (sh == 1) ? "R8" : (sh == (8 << g)) ? "R7" : "R6";
                send(mk_word(8 << g, sh, 5'(sh), 5'(g + 3)), rnd_vec(), rnd_vec(), tag);
            end
        end
        // R8 with all-zero source, all-ones destination
        send(mk_word(16, 1, 5'd1, 5'd2), '0, '1, "R8");
        // R7 with all-ones source
        send(mk_word(32, 32, 5'd4, 5'd5), '1, rnd_vec(), "R7");
        // R4 zero size field
        send({8'h45, 2'b00, 1'b0, 2'b00, 3'b101, 6'b111100, 5'd9, 5'd10}, rnd_vec(), rnd_vec(), "R4");
        // R3 wrong top byte, bit 21 set, wrong middle bits; R9 indices
        send({8'h44, 2'b01, 1'b0, 2'b00, 3'b000, 6'b111100, 5'd17, 5'd18}, rnd_vec(), rnd_vec(), "R3");
        send({8'h45, 2'b01, 1'b1, 2'b00, 3'b000, 6'b111100, 5'd19, 5'd20}, rnd_vec(), rnd_vec(), "R3");
        send({8'h45, 2'b01, 1'b0, 2'b00, 3'b000, 6'b111101, 5'd21, 5'd22}, rnd_vec(), rnd_vec(), "R9");
        // R2 with a gap, then R10 patterned vector
        idle();
        send(mk_word(8, 4, 5'd30, 5'd31), {VL/8{8'hF0}}, {VL/8{8'h5A}}, "R10");
        d = last_res;
        idle();
        repeat (4) @(negedge clk);
        // R11 hold while idle
        check(out_valid === 0 && out_result === d && out_rd === 5'd31,
              $sformatf("R11 hold: actual valid=%b res=%h expected 0 %h", out_valid, out_result, d));
        check(sb.size() == 0, $sformatf("R2 pending results: actual %0d expected 0", sb.size()));
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule